// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a one-cycle 32-bit arithmetic unit that performs clamped integer operations selected by an opcode. A caller presents two operands, an opcode and a bit position together with a one-cycle start strobe. On the following clock edge the unit registers the result and raises a one-cycle valid pulse. Signed and unsigned add and subtract, signed doubling, and clamping of a value to a signed or unsigned range given by a bit position are provided. The two range clamps also exist in a dual form that treats each 16-bit half as a separate signed number.

Each operation that has to clamp raises a shared sticky flag, and so does a wrapping add that leaves its sum unclamped. The flag stays raised until the caller pulses a dedicated clear input. When a clear and a new clamping event meet in the same cycle, the event wins.

The control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_EMIT` means the registered result is valid this cycle. A start strobe moves the machine from `ST_IDLE` to `ST_EMIT`, and a further start keeps it in `ST_EMIT` for back-to-back work. A cycle without a start returns it from `ST_EMIT` to `ST_IDLE`.

Top module: `satalu_core`

## Requirements
- R1: While reset is asserted (active low) and after its release, before any start, `result_o` is 0, `valid_o` is 0 and `sat_flag_o` is 0.
- R2: A start sampled on a clock edge makes `valid_o` high for the cycle after that edge, with `result_o` updated at the same edge. Back-to-back starts give back-to-back valid cycles. Without a start, `valid_o` is low and `result_o` holds its value.
- R3: Opcode 0 (signed add) and opcode 1 (signed subtract) return the two's-complement result. On signed overflow they return 0x7FFFFFFF if operand A is non-negative and 0x80000000 otherwise, and they raise the flag.
- R4: Opcode 9 (wrapping add) always returns the sum modulo 2^32 and raises the flag when the signed sum overflows.
- R5: Opcode 2 (unsigned add) returns 0xFFFFFFFF on carry out, and opcode 3 (unsigned subtract) returns 0 on borrow. Both raise the flag when they clamp.
- R6: Opcode 4 (signed doubling of A) returns 0x7FFFFFFF and raises the flag for A at or above 0x40000000. It returns 0x80000000 and raises the flag for A at or below 0xC0000000, this bound included. Otherwise it returns A shifted left by one.
- R7: Opcode 5 (signed clamp at position s = `pos_i`) returns A when A lies in [-2^s, 2^s-1]. Otherwise it returns the nearer bound and raises the flag.
- R8: Opcode 6 (unsigned clamp at position s) returns 0 for negative A and 2^s-1 for A above 2^s-1, raising the flag in both cases. Otherwise it returns A.
- R9: Opcodes 7 and 8 apply the R7 and R8 rules respectively to each sign-extended 16-bit half of A. The low half's result goes to bits 15:0 and the high half's to bits 31:16. Either half clamping raises the flag.
- R10: Once raised, the flag stays high through operations that do not clamp.
- R11: A clear with no clamping event drops the flag at the next edge. A clear in the same cycle as a clamping start leaves the flag high.
- R12: Opcodes 10 to 15 return 0 and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, one operation per cycle it is high |
| op_i | input | 4 | Operation select |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B (add/subtract forms only) |
| pos_i | input | 5 | Bit position s for the clamp forms, 0 to 31 |
| clr_i | input | 1 | Clear request for the sticky flag |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | High for the cycle after a start |
| sat_flag_o | output | 1 | Sticky clamp flag |

## Verification
The bench builds the unit with its default 32-bit data width, so the 16-bit halves and the 5-bit position take their full-size values. At this width the exact corner points can be reached directly: the signed extremes, 0xC0000000 in doubling, and position 0 and position 31 in the clamps. The dual forms can be driven with one half clamping and the other passing through. Clear requests are placed both alone and in the same cycle as a clamping start, and back-to-back starts exercise the `ST_EMIT` self-loop.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

    typedef enum logic [3:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_UADD   = 4'd2,
        OP_USUB   = 4'd3,
        OP_SDBL   = 4'd4,
        OP_SCLIP  = 4'd5,
        OP_UCLIP  = 4'd6,
        OP_SCLIP2 = 4'd7,
        OP_UCLIP2 = 4'd8,
        OP_WADD   = 4'd9
    } sat_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } sat_state_e;

endpackage

// File: rtl/satalu_addsub.sv
module satalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] diff_o,
    output logic         s_add_ovf_o,
    output logic         s_sub_ovf_o,
    output logic         u_carry_o,
    output logic         u_borrow_o
);

    logic [W:0] ext_sum;
    logic [W:0] ext_diff;

    always_comb begin
        ext_sum  = {1'b0, a_i} + {1'b0, b_i};
        ext_diff = {1'b0, a_i} - {1'b0, b_i};
        sum_o    = ext_sum[W-1:0];
        diff_o   = ext_diff[W-1:0];
        u_carry_o  = ext_sum[W];
        u_borrow_o = ext_diff[W];
        s_add_ovf_o = (a_i[W-1] == b_i[W-1]) && (ext_sum[W-1] != a_i[W-1]);
        s_sub_ovf_o = (a_i[W-1] != b_i[W-1]) && (ext_diff[W-1] != a_i[W-1]);
    end

    // R5
    always_comb begin
        carry_wrap_chk: assert (!u_carry_o || (sum_o < a_i));
    end

endmodule

// File: rtl/satalu_clamp.sv
module satalu_clamp #(
    parameter int W  = 32,
    parameter int PW = 5
) (
    input  logic [W-1:0]  val_i,
    input  logic [PW-1:0] pos_i,
    input  logic          signed_i,
    output logic [W-1:0]  res_o,
    output logic          hit_o
);

    logic [W-1:0] mask;
    logic [W-1:0] top;
    logic         above;
    logic         below;
    logic         u_neg;
    logic         u_over;

    always_comb begin
        mask   = ({{(W-1){1'b0}}, 1'b1} << pos_i) - {{(W-1){1'b0}}, 1'b1};
        top    = $signed(val_i) >>> pos_i;
        above  = !top[W-1] && (|top);
        below  = top[W-1] && !(&top);
        u_neg  = val_i[W-1];
        u_over = !u_neg && (val_i > mask);
        if (signed_i) begin
            hit_o = above || below;
            if (above)      res_o = mask;
            else if (below) res_o = ~mask;
            else            res_o = val_i;
        end else begin
            hit_o = u_neg || u_over;
            if (u_neg)       res_o = '0;
            else if (u_over) res_o = mask;
            else             res_o = val_i;
        end
    end

endmodule

// File: rtl/satalu_core.sv
module satalu_core #(
    parameter int DATA_W = 32
) (
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic                      start_i,
    input  logic [3:0]                op_i,
    input  logic [DATA_W-1:0]         opa_i,
    input  logic [DATA_W-1:0]         opb_i,
    input  logic [$clog2(DATA_W)-1:0] pos_i,
    input  logic                      clr_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      valid_o,
    output logic                      sat_flag_o
);
    import satalu_pkg::*;

    localparam int HALF_W = DATA_W / 2;
    localparam int POS_W  = $clog2(DATA_W);

    sat_state_e state_q, state_d;
    sat_op_e    op_sel;

    logic [DATA_W-1:0] sum, diff;
    logic s_add_ovf, s_sub_ovf, u_carry, u_borrow;
    logic [DATA_W-1:0] smax, smin, s_clip_val;
    logic dbl_hi, dbl_lo;
    logic full_signed, half_signed;
    logic [DATA_W-1:0] full_res;
    logic full_hit;
    logic [DATA_W-1:0] half_res [2];
    logic [1:0] half_hit;
    logic [DATA_W-1:0] nxt_res;
    logic nxt_hit;
    logic [DATA_W-1:0] result_q;
    logic flag_q;

    assign op_sel = sat_op_e'(op_i);

    satalu_addsub #(.W(DATA_W)) u_addsub (
        .a_i        (opa_i),
        .b_i        (opb_i),
        .sum_o      (sum),
        .diff_o     (diff),
        .s_add_ovf_o(s_add_ovf),
        .s_sub_ovf_o(s_sub_ovf),
        .u_carry_o  (u_carry),
        .u_borrow_o (u_borrow)
    );

    assign full_signed = (op_sel == OP_SCLIP);
    assign half_signed = (op_sel == OP_SCLIP2);

    satalu_clamp #(.W(DATA_W), .PW(POS_W)) u_full (
        .val_i   (opa_i),
        .pos_i   (pos_i),
        .signed_i(full_signed),
        .res_o   (full_res),
        .hit_o   (full_hit)
    );

    for (genvar k = 0; k < 2; k++) begin : g_half
        logic [HALF_W-1:0] part;
        assign part = opa_i[k*HALF_W +: HALF_W];
        satalu_clamp #(.W(DATA_W), .PW(POS_W)) u_lane (
            .val_i   ({{(DATA_W-HALF_W){part[HALF_W-1]}}, part}),
            .pos_i   (pos_i),
            .signed_i(half_signed),
            .res_o   (half_res[k]),
            .hit_o   (half_hit[k])
        );
    end

    always_comb begin
        smax       = {1'b0, {(DATA_W-1){1'b1}}};
        smin       = {1'b1, {(DATA_W-1){1'b0}}};
        s_clip_val = opa_i[DATA_W-1] ? smin : smax;
        dbl_hi     = !opa_i[DATA_W-1] && opa_i[DATA_W-2];
        dbl_lo     = opa_i[DATA_W-1] &&
                     (!opa_i[DATA_W-2] || (opa_i[DATA_W-3:0] == '0));
    end

    always_comb begin
        nxt_res = '0;
        nxt_hit = 1'b0;
        unique case (op_sel)
            OP_SADD: begin
                nxt_hit = s_add_ovf;
                nxt_res = s_add_ovf ? s_clip_val : sum;
            end
            OP_SSUB: begin
                nxt_hit = s_sub_ovf;
                nxt_res = s_sub_ovf ? s_clip_val : diff;
            end
            OP_UADD: begin
                nxt_hit = u_carry;
                nxt_res = u_carry ? '1 : sum;
            end
            OP_USUB: begin
                nxt_hit = u_borrow;
                nxt_res = u_borrow ? '0 : diff;
            end
            OP_SDBL: begin
                nxt_hit = dbl_hi || dbl_lo;
                if (dbl_hi)      nxt_res = smax;
                else if (dbl_lo) nxt_res = smin;
                else             nxt_res = opa_i << 1;
            end
            OP_SCLIP, OP_UCLIP: begin
                nxt_hit = full_hit;
                nxt_res = full_res;
            end
            OP_SCLIP2, OP_UCLIP2: begin
                nxt_hit = |half_hit;
                nxt_res = {half_res[1][HALF_W-1:0], half_res[0][HALF_W-1:0]};
            end
            OP_WADD: begin
                nxt_hit = s_add_ovf;
                nxt_res = sum;
            end
            default: begin
                nxt_hit = 1'b0;
                nxt_res = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_EMIT;
            ST_EMIT: state_d = start_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            result_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (start_i) result_q <= nxt_res;
            if (start_i && nxt_hit) flag_q <= 1'b1;
            else if (clr_i)         flag_q <= 1'b0;
        end
    end

    assign result_o   = result_q;
    assign valid_o    = (state_q == ST_EMIT);
    assign sat_flag_o = flag_q;

    // R2
    valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        start_i |=> valid_o);
    // R2
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !start_i |=> (!valid_o && $stable(result_o)));
    // R10
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!start_i && !clr_i) |=> $stable(sat_flag_o));
    // R11
    flag_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (start_i && nxt_hit) |=> sat_flag_o);
    // R11
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_i && !(start_i && nxt_hit)) |=> !sat_flag_o);

endmodule

// File: tb/satalu_core_tb_top.sv
module satalu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  pos = '0;
    logic        clr = 1'b0;
    logic [31:0] result;
    logic        valid;
    logic        sat_flag;

    int errors = 0;
    int checks = 0;
    logic model_flag = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        flag;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    satalu_core #(.DATA_W(32)) dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .op_i(op),
        .opa_i(opa), .opb_i(opb), .pos_i(pos), .clr_i(clr),
        .result_o(result), .valid_o(valid), .sat_flag_o(sat_flag)
    );

    function automatic longint fit(input longint v, input longint lo,
                                   input longint hi, inout logic h);
        if (v < lo) begin h = 1'b1; return lo; end
        if (v > hi) begin h = 1'b1; return hi; end
        return v;
    endfunction

    function automatic void model(input logic [3:0] o, input logic [31:0] a,
                                  input logic [31:0] b, input logic [4:0] p,
                                  output logic [31:0] r, output logic h);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint smx = 64'sd2147483647;
        longint smn = -64'sd2147483648;
        longint lim = (64'sd1 <<< p);
        longint lo16, hi16, rl, rh;
        h = 1'b0;
        r = '0;
        lo16 = longint'($signed(a[15:0]));
        hi16 = longint'($signed(a[31:16]));
        case (o)
            4'd0: r = 32'(fit(sa + sb, smn, smx, h));
            4'd1: r = 32'(fit(sa - sb, smn, smx, h));
            4'd2: r = 32'(fit(ua + ub, 0, 64'sd4294967295, h));
            4'd3: r = 32'(fit(ua - ub, 0, 64'sd4294967295, h));
            4'd4: begin
                if (sa >= 64'sd1073741824)       begin r = 32'h7FFFFFFF; h = 1'b1; end
                else if (sa <= -64'sd1073741824) begin r = 32'h80000000; h = 1'b1; end
                else r = 32'(sa * 2);
            end
            4'd5: r = 32'(fit(sa, -lim, lim - 1, h));
            4'd6: r = 32'(fit(sa, 0, lim - 1, h));
            4'd7: begin
                rl = fit(lo16, -lim, lim - 1, h);
                rh = fit(hi16, -lim, lim - 1, h);
                r = {rh[15:0], rl[15:0]};
            end
            4'd8: begin
                rl = fit(lo16, 0, lim - 1, h);
                rh = fit(hi16, 0, lim - 1, h);
                r = {rh[15:0], rl[15:0]};
            end
            4'd9: begin
                r = a + b;
                if ((sa + sb > smx) || (sa + sb < smn)) h = 1'b1;
            end
            default: begin r = '0; h = 1'b0; end
        endcase
    endfunction

    task automatic issue(input logic [3:0] o, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] p,
                         input logic c, input string tag);
        exp_t e;
        logic [31:0] r;
        logic h;
        model(o, a, b, p, r, h);
        if (h) model_flag = 1'b1;
        else if (c) model_flag = 1'b0;
        e.res = r; e.flag = model_flag; e.tag = tag;
        @(posedge clk);
        #1;
        sb_q.push_back(e);
        start = 1'b1; op = o; opa = a; opb = b; pos = p; clr = c;
    endtask

    task automatic go_idle(input int n);
        @(posedge clk);
        #1;
        start = 1'b0; clr = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_only;
        @(posedge clk);
        #1;
        start = 1'b0; clr = 1'b1;
        model_flag = 1'b0;
        @(posedge clk);
        #1;
        clr = 1'b0;
        @(negedge clk);
        checks++;
        if (sat_flag !== 1'b0) begin
            errors++;
            $display("FAIL R11 clear alone: flag=%0b expected 0", sat_flag);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && valid === 1'b1) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected valid: result=%h expected none", result);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (result !== e.res || sat_flag !== e.flag) begin
                        errors++;
                        $display("FAIL %s result=%h flag=%0b expected result=%h flag=%0b",
                                 e.tag, result, sat_flag, e.res, e.flag);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: run=hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== '0 || valid !== 1'b0 || sat_flag !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: result=%h valid=%0b flag=%0b expected 0 0 0",
                     result, valid, sat_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (result !== '0 || valid !== 1'b0 || sat_flag !== 1'b0) begin
            errors++;
            $display("FAIL R1 after release: result=%h valid=%0b flag=%0b expected 0 0 0",
                     result, valid, sat_flag);
        end

        // R3 signed add / subtract, back-to-back (R2)
        issue(4'd0, 32'd5, 32'd7, 5'd0, 1'b0, "R3 sadd plain");
        issue(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, "R3 sadd high clamp");
        issue(4'd0, 32'd1, 32'd1, 5'd0, 1'b0, "R10 flag stays");
        clear_only();
        issue(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b0, "R3 sadd low clamp");
        issue(4'd9, 32'd1, 32'd2, 5'd0, 1'b1, "R11 clear with quiet start");
        issue(4'd1, 32'h80000000, 32'd1, 5'd0, 1'b0, "R3 ssub low clamp");
        issue(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0, "R3 ssub high clamp");
        issue(4'd2, 32'hFFFFFFFF, 32'd2, 5'd0, 1'b1, "R11 set wins over clear");
        go_idle(1);
        checks++;
        if (sat_flag !== 1'b1) begin
            errors++;
            $display("FAIL R11 set wins: flag=%0b expected 1", sat_flag);
        end
        clear_only();

        // R4 wrapping add
        issue(4'd9, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, "R4 wadd overflow");
        go_idle(0);
        clear_only();
        issue(4'd9, 32'd10, 32'd20, 5'd0, 1'b0, "R4 wadd plain");

        // R5 unsigned
        issue(4'd2, 32'd1, 32'd2, 5'd0, 1'b0, "R5 uadd plain");
        issue(4'd3, 32'd5, 32'd7, 5'd0, 1'b0, "R5 usub borrow");
        go_idle(0);
        clear_only();
        issue(4'd3, 32'd7, 32'd5, 5'd0, 1'b0, "R5 usub plain");

        // R6 doubling
        issue(4'd4, 32'h20000000, 32'd0, 5'd0, 1'b0, "R6 dbl plain");
        issue(4'd4, 32'h3FFFFFFF, 32'd0, 5'd0, 1'b0, "R6 dbl top in range");
        issue(4'd4, 32'hC0000001, 32'd0, 5'd0, 1'b0, "R6 dbl bottom in range");
        issue(4'd4, 32'hC0000000, 32'd0, 5'd0, 1'b0, "R6 dbl bound low");
        go_idle(0);
        clear_only();
        issue(4'd4, 32'h40000000, 32'd0, 5'd0, 1'b0, "R6 dbl bound high");
        go_idle(0);
        clear_only();

        // R7 signed clamp
        issue(4'd5, 32'd100, 32'd0, 5'd7, 1'b0, "R7 sclip pass");
        issue(4'd5, 32'd300, 32'd0, 5'd7, 1'b0, "R7 sclip high");
        go_idle(0);
        clear_only();
        issue(4'd5, 32'hFFFFFF80, 32'd0, 5'd7, 1'b0, "R7 sclip low bound pass");
        issue(4'd5, 32'hFFFFFF7F, 32'd0, 5'd7, 1'b0, "R7 sclip low");
        go_idle(0);
        clear_only();
        issue(4'd5, 32'd0, 32'd0, 5'd0, 1'b0, "R7 sclip pos0");
        issue(4'd5, 32'h80000000, 32'd0, 5'd31, 1'b0, "R7 sclip pos31");

        // R8 unsigned clamp
        issue(4'd6, 32'd255, 32'd0, 5'd8, 1'b0, "R8 uclip pass");
        issue(4'd6, 32'd256, 32'd0, 5'd8, 1'b0, "R8 uclip high");
        go_idle(0);
        clear_only();
        issue(4'd6, 32'hFFFFFFFF, 32'd0, 5'd8, 1'b0, "R8 uclip negative");
        go_idle(0);
        clear_only();
        issue(4'd6, 32'd0, 32'd0, 5'd0, 1'b0, "R8 uclip pos0");

        // R9 dual halves
        issue(4'd7, 32'h0100FF00, 32'd0, 5'd7, 1'b0, "R9 sclip2 both");
        go_idle(0);
        clear_only();
        issue(4'd7, 32'h0005FFFE, 32'd0, 5'd7, 1'b0, "R9 sclip2 pass");
        issue(4'd7, 32'h00017FFF, 32'd0, 5'd3, 1'b0, "R9 sclip2 low only");
        go_idle(0);
        clear_only();
        issue(4'd8, 32'hFFF00020, 32'd0, 5'd4, 1'b0, "R9 uclip2 both");
        go_idle(0);
        clear_only();
        issue(4'd8, 32'h000A0003, 32'd0, 5'd4, 1'b0, "R9 uclip2 pass");

        // R12 undefined opcodes
        issue(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b0, "R3 set before undefined");
        issue(4'hC, 32'd123, 32'd4, 5'd3, 1'b0, "R12 undefined keeps flag");
        go_idle(0);
        clear_only();
        issue(4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd31, 1'b0, "R12 undefined zero");
        go_idle(1);

        // R2 idle hold
        @(negedge clk);
        held = result;
        repeat (3) @(negedge clk);
        checks++;
        if (valid !== 1'b0 || result !== held) begin
            errors++;
            $display("FAIL R2 idle hold: valid=%0b result=%h expected 0 %h",
                     valid, result, held);
        end
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing results: pending=%0d expected 0", sb_q.size());
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule